// File: doc/BRIEF.md
# Bidirectional Axle Crossing Detector

This block watches two beam sensors mounted a short distance apart along a rail. A sensor reads 0 while its beam is clear and 1 while an axle blocks it. The block works out the direction of travel from the order in which the beams are blocked and cleared. It raises a one-clock pulse on `fwd_pulse_o` for each complete crossing from the A side to the B side, and on `rev_pulse_o` for each complete crossing from the B side to the A side. The pulses are meant to drive event counters further on.

Both sensor lines are asynchronous, so each one passes through a chain of synchronizing flops before the state machine sees it. The machine is of Moore type. An axle may stop anywhere inside the sensor zone for any length of time. It may also back out. Only an axle that leaves on the side opposite to where it came in is counted.

A saturating wear counter adds up the crossings in both directions. Once the count reaches `WEAR_LIMIT` it raises a sticky alarm, which only reset clears.

The states, written as beam pair {A,B}, are as follows:
- `ST_IDLE` (00 expected).
- Forward progress: `ST_L_ENTER` (10), `ST_L_MID` (11), `ST_L_EXIT` (01), then `ST_L_DONE`, which raises the forward pulse.
- Reverse progress: `ST_R_ENTER` (01), `ST_R_MID` (11), `ST_R_EXIT` (10), then `ST_R_DONE`, which raises the reverse pulse.

The transitions are as follows:
- **Hold:** a state keeps itself while its own beam pair persists.
- **Advance:** each state moves to the next stage when the next pair of its direction appears.
- **Retreat:** each state moves back one stage when the previous pair appears. From an enter state, a retreat leads to `ST_IDLE`.
- **Illegal jump:** a pair that differs in both bits from the expected one leads to `ST_IDLE`.
- **Restart:** `ST_IDLE` and both done states choose their next state from the current pair, in the same way as `ST_IDLE` does.

Top module: `axle_xing_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, `fwd_pulse_o` and `rev_pulse_o` are 0.
- R2: The sequence {A,B} = 00, 10, 11, 01, 00 yields exactly one `fwd_pulse_o` pulse, one clock wide, and no `rev_pulse_o`.
- R3: The sequence 01, 11, 10, 00 from idle yields exactly one `rev_pulse_o` pulse, one clock wide, and no `fwd_pulse_o`.
- R4: An axle can stop at any intermediate pair for any number of cycles without losing progress. Completing the pass later still yields its pulse.
- R5: An axle that enters and then backs out to the side it came from yields no pulse, wherever it reverses.
- R6: Back-and-forth movement inside the zone, followed by an exit on the far side, yields exactly one pulse for the direction of entry.
- R7: A jump in which both beam bits change at once abandons the pass without a pulse, and the machine restarts from idle. A later full pass is counted normally.
- R8: A pulse appears in the third clock cycle after the final 00 pair is presented: two synchronizer stages plus the state register.
- R9: `fwd_pulse_o` and `rev_pulse_o` are never high in the same cycle.
- R10: `wear_count_o` rises by one in the cycle after each pulse of either direction, and saturates at `WEAR_LIMIT`. `wear_alarm_o` becomes 1 in that same cycle once the count reaches `WEAR_LIMIT`, and then stays at 1.
- R11: A synchronous active-high reset clears the state machine, `wear_count_o` and `wear_alarm_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| beam_a_i | input | 1 | Sensor A, 1 while blocked (asynchronous) |
| beam_b_i | input | 1 | Sensor B, 1 while blocked (asynchronous) |
| fwd_pulse_o | output | 1 | One-clock pulse per A-to-B crossing |
| rev_pulse_o | output | 1 | One-clock pulse per B-to-A crossing |
| wear_count_o | output | CNT_W ($clog2(WEAR_LIMIT+1), 17 by default) | Total crossings, saturating |
| wear_alarm_o | output | 1 | Sticky flag, set when the count reaches WEAR_LIMIT |

## Verification
The bench builds the block with `WEAR_LIMIT` = 6 and the default two synchronizer stages. The small limit makes the alarm and the saturation of the counter reachable within a few dozen crossings, while the stage count fixes the three-cycle pulse latency that the scoreboard expects. Each expected pulse is queued together with its exact cycle, so a pulse that is early, late, in the wrong direction or not expected at all is caught.

// File: rtl/axle_pkg.sv
package axle_pkg;

    // Beam pair encoding: bit 1 is sensor A, bit 0 is sensor B, 1 = blocked
    localparam logic [1:0] BEAM_CLEAR = 2'b00;
    localparam logic [1:0] BEAM_A     = 2'b10;
    localparam logic [1:0] BEAM_B     = 2'b01;
    localparam logic [1:0] BEAM_BOTH  = 2'b11;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_L_ENTER,
        ST_L_MID,
        ST_L_EXIT,
        ST_L_DONE,
        ST_R_ENTER,
        ST_R_MID,
        ST_R_EXIT,
        ST_R_DONE
    } axle_state_e;

endpackage

// File: rtl/axle_sync.sv
module axle_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    // Stage 0 samples the raw lines; each later stage samples its predecessor
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= '0;
                else     chain_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= '0;
                else     chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/axle_dir_fsm.sv
module axle_dir_fsm
    import axle_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] beams_i,
    output logic       fwd_o,
    output logic       rev_o
);

    axle_state_e state_q;
    axle_state_e state_d;

    // Choice of next state wherever the zone is assumed empty
    function automatic axle_state_e from_clear(input logic [1:0] ab);
        axle_state_e nxt;
        case (ab)
            BEAM_A:  nxt = ST_L_ENTER;
            BEAM_B:  nxt = ST_R_ENTER;
            default: nxt = ST_IDLE;   // stays clear, or both blocked at once
        endcase
        return nxt;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_L_DONE, ST_R_DONE: begin
                state_d = from_clear(beams_i);
            end
            ST_L_ENTER: begin
                case (beams_i)
                    BEAM_A:     state_d = ST_L_ENTER;
                    BEAM_BOTH:  state_d = ST_L_MID;
                    BEAM_CLEAR: state_d = ST_IDLE;     // backed out
                    default:    state_d = ST_IDLE;     // double-bit jump
                endcase
            end
            ST_L_MID: begin
                case (beams_i)
                    BEAM_BOTH:  state_d = ST_L_MID;
                    BEAM_B:     state_d = ST_L_EXIT;
                    BEAM_A:     state_d = ST_L_ENTER;  // reversing
                    default:    state_d = ST_IDLE;     // double-bit jump
                endcase
            end
            ST_L_EXIT: begin
                case (beams_i)
                    BEAM_B:     state_d = ST_L_EXIT;
                    BEAM_CLEAR: state_d = ST_L_DONE;
                    BEAM_BOTH:  state_d = ST_L_MID;    // reversing
                    default:    state_d = ST_IDLE;     // double-bit jump
                endcase
            end
            ST_R_ENTER: begin
                case (beams_i)
                    BEAM_B:     state_d = ST_R_ENTER;
                    BEAM_BOTH:  state_d = ST_R_MID;
                    BEAM_CLEAR: state_d = ST_IDLE;     // backed out
                    default:    state_d = ST_IDLE;     // double-bit jump
                endcase
            end
            ST_R_MID: begin
                case (beams_i)
                    BEAM_BOTH:  state_d = ST_R_MID;
                    BEAM_A:     state_d = ST_R_EXIT;
                    BEAM_B:     state_d = ST_R_ENTER;  // reversing
                    default:    state_d = ST_IDLE;     // double-bit jump
                endcase
            end
            ST_R_EXIT: begin
                case (beams_i)
                    BEAM_A:     state_d = ST_R_EXIT;
                    BEAM_CLEAR: state_d = ST_R_DONE;
                    BEAM_BOTH:  state_d = ST_R_MID;    // reversing
                    default:    state_d = ST_IDLE;     // double-bit jump
                endcase
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Moore outputs: a function of the state register alone
    always_comb begin
        fwd_o = 1'b0;
        rev_o = 1'b0;
        unique case (state_q)
            ST_L_DONE: fwd_o = 1'b1;
            ST_R_DONE: rev_o = 1'b1;
            default: begin
                fwd_o = 1'b0;
                rev_o = 1'b0;
            end
        endcase
    end

    // R9
    no_both_chk: assert property (@(posedge clk) disable iff (rst)
        !(fwd_o && rev_o));

    // R2
    fwd_single_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_o |=> !fwd_o);

    // R3
    rev_single_chk: assert property (@(posedge clk) disable iff (rst)
        rev_o |=> !rev_o);

    // R7
    idle_both_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && beams_i == BEAM_BOTH) |=> (!fwd_o && !rev_o));

endmodule

// File: rtl/axle_wear_cnt.sv
module axle_wear_cnt #(
    parameter int unsigned WEAR_LIMIT = 100000,
    localparam int CNT_W = $clog2(WEAR_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fwd_i,
    input  logic             rev_i,
    output logic [CNT_W-1:0] count_o,
    output logic             alarm_o
);

    localparam logic [CNT_W-1:0] LAST_BEFORE = CNT_W'(WEAR_LIMIT - 1);
    localparam logic [CNT_W-1:0] TOP_COUNT   = CNT_W'(WEAR_LIMIT);

    logic [CNT_W-1:0] count_q;
    logic             alarm_q;
    logic             hit;

    assign hit = fwd_i | rev_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            alarm_q <= 1'b0;
        end else if (hit && count_q != TOP_COUNT) begin
            count_q <= count_q + 1'b1;
            if (count_q == LAST_BEFORE) alarm_q <= 1'b1;
        end
    end

    assign count_o = count_q;
    assign alarm_o = alarm_q;

    // R10
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_q |=> alarm_q);

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count_q <= TOP_COUNT);

    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (count_q != $past(count_q)) |-> (count_q == CNT_W'($past(count_q) + 1'b1)));

    // R10
    alarm_match_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_q == (count_q == TOP_COUNT));

endmodule

// File: rtl/axle_xing_top.sv
module axle_xing_top #(
    parameter int unsigned WEAR_LIMIT  = 100000,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int CNT_W = $clog2(WEAR_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beam_a_i,
    input  logic             beam_b_i,
    output logic             fwd_pulse_o,
    output logic             rev_pulse_o,
    output logic [CNT_W-1:0] wear_count_o,
    output logic             wear_alarm_o
);

    logic [1:0] beams_sync;
    logic       fwd;
    logic       rev;

    axle_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({beam_a_i, beam_b_i}),
        .sync_o  (beams_sync)
    );

    axle_dir_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .beams_i (beams_sync),
        .fwd_o   (fwd),
        .rev_o   (rev)
    );

    axle_wear_cnt #(
        .WEAR_LIMIT (WEAR_LIMIT)
    ) u_wear (
        .clk     (clk),
        .rst     (rst),
        .fwd_i   (fwd),
        .rev_i   (rev),
        .count_o (wear_count_o),
        .alarm_o (wear_alarm_o)
    );

    assign fwd_pulse_o = fwd;
    assign rev_pulse_o = rev;

    // R10
    count_follows_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (!fwd && !rev) |=> $stable(wear_count_o));

endmodule

// File: tb/axle_xing_top_tb.sv
module axle_xing_top_tb;

    localparam int unsigned LIMIT = 6;
    localparam int CW = $clog2(LIMIT + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          beam_a = 1'b0;
    logic          beam_b = 1'b0;
    logic          fwd;
    logic          rev;
    logic [CW-1:0] wcount;
    logic          walarm;

    int cyc    = 0;
    int checks = 0;
    int bad    = 0;
    bit done   = 1'b0;

    int exp_dir_q[$];   // 1 = forward, 2 = reverse
    int exp_cyc_q[$];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc++;

    axle_xing_top #(
        .WEAR_LIMIT  (LIMIT),
        .SYNC_STAGES (2)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .beam_a_i     (beam_a),
        .beam_b_i     (beam_b),
        .fwd_pulse_o  (fwd),
        .rev_pulse_o  (rev),
        .wear_count_o (wcount),
        .wear_alarm_o (walarm)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Driver: called at a falling edge; presents a pair and holds it.
    // expect_dir: 0 none, 1 forward pulse, 2 reverse pulse (R8: three cycles later)
    task automatic step(input logic [1:0] ab, input int hold, input int expect_dir);
        {beam_a, beam_b} = ab;
        if (expect_dir != 0) begin
            exp_dir_q.push_back(expect_dir);
            exp_cyc_q.push_back(cyc + 3);
        end
        repeat (hold) @(negedge clk);
    endtask

    task automatic settle(input string req);
        repeat (8) @(negedge clk);
        check(exp_dir_q.size() == 0, req, exp_dir_q.size(), 0);
    endtask

    // Monitor: compares every produced pulse with the queue head
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (fwd && rev) check(1'b0, "R9 both pulses", 1, 0);
            if (fwd || rev) begin
                if (exp_dir_q.size() == 0) begin
                    check(1'b0, "R5/R7 unexpected pulse", fwd ? 1 : 2, 0);
                end else begin
                    int d;
                    int c;
                    d = exp_dir_q.pop_front();
                    c = exp_cyc_q.pop_front();
                    check((fwd ? 1 : 2) == d, "R2/R3 direction", fwd ? 1 : 2, d);
                    check(cyc == c, "R8 pulse cycle", cyc, c);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1, R11: reset state
        check(fwd == 1'b0 && rev == 1'b0, "R1 pulses in reset", {fwd, rev}, 0);
        check(wcount == 0, "R11 count in reset", wcount, 0);
        check(walarm == 1'b0, "R11 alarm in reset", walarm, 0);
        rst = 1'b0;
        @(negedge clk);
        check(fwd == 1'b0 && rev == 1'b0, "R1 after reset", {fwd, rev}, 0);
        step(2'b00, 3, 0);

        // R2 forward pass
        step(2'b10, 3, 0); step(2'b11, 3, 0); step(2'b01, 3, 0); step(2'b00, 4, 1);
        settle("R2");
        // R3 reverse pass
        step(2'b01, 2, 0); step(2'b11, 2, 0); step(2'b10, 2, 0); step(2'b00, 4, 2);
        settle("R3");
        check(wcount == 2, "R10 both directions counted", wcount, 2);

        // R4 long stops at every intermediate pair
        step(2'b10, 40, 0); step(2'b11, 55, 0); step(2'b01, 30, 0); step(2'b00, 4, 1);
        settle("R4");

        // R5 back-outs at each depth, both sides
        step(2'b10, 3, 0); step(2'b00, 3, 0);
        step(2'b10, 3, 0); step(2'b11, 3, 0); step(2'b10, 3, 0); step(2'b00, 3, 0);
        step(2'b01, 3, 0); step(2'b11, 3, 0); step(2'b10, 3, 0); step(2'b11, 2, 0);
        step(2'b01, 2, 0); step(2'b00, 3, 0);
        settle("R5");
        check(wcount == 3, "R5 count unchanged", wcount, 3);

        // R6 wobble then exit far side
        step(2'b10, 2, 0); step(2'b11, 2, 0); step(2'b10, 2, 0); step(2'b11, 2, 0);
        step(2'b01, 2, 0); step(2'b11, 2, 0); step(2'b01, 2, 0); step(2'b00, 4, 1);
        settle("R6 forward");
        step(2'b01, 1, 0); step(2'b11, 1, 0); step(2'b10, 1, 0); step(2'b11, 1, 0);
        step(2'b10, 1, 0); step(2'b00, 4, 2);
        settle("R6 reverse");
        check(wcount == 5 && walarm == 1'b0, "R10 below limit", {walarm, wcount}, 5);

        // R7 double-bit jumps
        step(2'b11, 3, 0); step(2'b00, 3, 0);
        step(2'b10, 3, 0); step(2'b01, 3, 0); step(2'b00, 3, 0);
        step(2'b10, 2, 0); step(2'b11, 2, 0); step(2'b00, 3, 0);
        settle("R7 no pulse");
        check(wcount == 5, "R7 count unchanged", wcount, 5);
        step(2'b10, 2, 0); step(2'b11, 2, 0); step(2'b01, 2, 0); step(2'b00, 4, 1);
        settle("R7 recovery");

        // R10 alarm at limit, saturation
        check(wcount == LIMIT, "R10 count at limit", wcount, LIMIT);
        check(walarm == 1'b1, "R10 alarm set", walarm, 1);
        step(2'b01, 2, 0); step(2'b11, 2, 0); step(2'b10, 2, 0); step(2'b00, 4, 2);
        settle("R10 extra pass");
        check(wcount == LIMIT, "R10 saturation", wcount, LIMIT);
        check(walarm == 1'b1, "R10 alarm sticky", walarm, 1);

        // R11 reset clears counter and alarm
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(wcount == 0, "R11 count cleared", wcount, 0);
        check(walarm == 1'b0, "R11 alarm cleared", walarm, 0);
        step(2'b10, 2, 0); step(2'b11, 2, 0); step(2'b01, 2, 0); step(2'b00, 4, 1);
        settle("R11 pass after reset");
        check(wcount == 1, "R11 counting resumes", wcount, 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule